// File: doc/BRIEF.md
# Paired-Page Translation Buffer Lookup

This block translates a 32-bit virtual address to a physical address using a small, fully associative set of sixteen translation entries. Each entry describes two neighbouring 4 KB pages that share a single tag. One tag holds the upper virtual bits, an address-space number and a global flag. Each page of the pair has its own frame number, valid flag and dirty flag. A lookup strobe presents the address, the current address-space number and a store flag. One clock later the block reports one of four outcomes. It returns a translation with its read and write rights, or it names the kind of fault: no entry matched, the selected page is not valid, or a store hit a page that is not yet dirty.

The entries are loaded through a simple indexed write port, and one cycle is enough to replace any entry. Choosing which entry to replace, and turning a fault into a trap, are the job of the surrounding logic. The address-space number and the store flag travel with each lookup, so the block keeps no mode state of its own.

Top module: `pgpair_tlb`

## Requirements
- R1: Synchronous active-high reset sets `rsp_valid` low and zeroes every field of every entry, all valid flags included. After reset, a lookup of address-space 0 in virtual page pair 0 therefore returns status 2'b10. Any lookup outside pair 0, or with a non-zero address-space number, returns 2'b01.
- R2: `rsp_valid` is high in exactly the cycle that follows a cycle with `req_valid` high. The response fields are registered in that same cycle.
- R3: An entry matches when its stored tag equals `req_va[31:13]` and, in addition, its global flag is set or its stored address-space number equals `req_asid`.
- R4: `req_va[12]` picks the half of the matching entry that is used: 0 selects the even half and 1 selects the odd half. Each half has its own frame number, valid flag and dirty flag.
- R5: On a translation, `rsp_pa` is the selected 20-bit frame number in bits 31:12, with `req_va[11:0]` unchanged in bits 11:0.
- R6: When no entry matches, `rsp_status` is 2'b01 (miss).
- R7: When an entry matches but its selected half has the valid flag clear, `rsp_status` is 2'b10 (invalid). This applies to both loads and stores.
- R8: A store to a valid half whose dirty flag is clear gives `rsp_status` 2'b11 (modified). A load of the same half gives 2'b00.
- R9: Status 2'b00 (hit) always sets `rsp_rd_ok`, and sets `rsp_wr_ok` exactly when the selected dirty flag is set. Every other status returns `rsp_pa`, `rsp_rd_ok` and `rsp_wr_ok` as zero.
- R10: When several entries match, the entry with the lowest index supplies the result.
- R11: A write with `wr_en` high replaces entry `wr_idx` completely, and lookups made from the next cycle on use the new contents. A lookup in the same cycle as the write still uses the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup strobe |
| req_va | input | 32 | Virtual address to translate |
| req_asid | input | 8 | Current address-space number |
| req_store | input | 1 | 1 for a store, 0 for a load |
| rsp_valid | output | 1 | Response present (one cycle after strobe) |
| rsp_status | output | 2 | 00 hit, 01 miss, 10 invalid, 11 modified |
| rsp_pa | output | 32 | Translated physical address (zero unless hit) |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry to replace |
| wr_vpn2 | input | 19 | Tag: virtual address bits 31:13 |
| wr_asid | input | 8 | Address-space number of the entry |
| wr_global | input | 1 | Match regardless of address-space number |
| wr_even_pfn | input | 20 | Frame number of the even page |
| wr_even_v | input | 1 | Even page valid |
| wr_even_d | input | 1 | Even page dirty (writable) |
| wr_odd_pfn | input | 20 | Frame number of the odd page |
| wr_odd_v | input | 1 | Odd page valid |
| wr_odd_d | input | 1 | Odd page dirty (writable) |

## Verification
An entry write and a lookup can arrive in the same cycle, and the lookup may even target the entry being replaced. The bench provokes this case by raising `wr_en` and `req_valid` on the same clock. The write installs a mapping for a page pair that no entry matched before. The response to that lookup must still be a miss, because it uses the old contents. A second lookup one cycle later must return the new translation. A response of hit on the first lookup, or of miss on the second, shows that the write and lookup ordering is wrong.

// File: rtl/pgpair_tlb_pkg.sv
package pgpair_tlb_pkg;

  // Lookup outcome, as driven on rsp_status.
  typedef enum logic [1:0] {
    ST_HIT      = 2'b00,
    ST_MISS     = 2'b01,
    ST_INVALID  = 2'b10,
    ST_MODIFIED = 2'b11
  } xlat_status_e;

  // Index of the even and odd halves inside an entry.
  localparam int HALF_EVEN = 0;
  localparam int HALF_ODD  = 1;

endpackage

// File: rtl/pgpair_tlb_store.sv
module pgpair_tlb_store #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int VPN2_W  = 19,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic [VPN2_W-1:0]                  wr_vpn2,
  input  logic [ASID_W-1:0]                  wr_asid,
  input  logic                               wr_global,
  input  logic [1:0][PFN_W-1:0]              wr_pfn,
  input  logic [1:0]                         wr_v,
  input  logic [1:0]                         wr_d,
  output logic [ENTRIES-1:0][VPN2_W-1:0]     ent_vpn2,
  output logic [ENTRIES-1:0][ASID_W-1:0]     ent_asid,
  output logic [ENTRIES-1:0]                 ent_global,
  output logic [ENTRIES-1:0][1:0][PFN_W-1:0] ent_pfn,
  output logic [ENTRIES-1:0][1:0]            ent_v,
  output logic [ENTRIES-1:0][1:0]            ent_d
);

  // Every entry is read in parallel each cycle, so the array lives in flops.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_vpn2[e]   <= '0;
        ent_asid[e]   <= '0;
        ent_global[e] <= 1'b0;
        ent_pfn[e]    <= '0;
        ent_v[e]      <= '0;
        ent_d[e]      <= '0;
      end else if (sel) begin
        ent_vpn2[e]   <= wr_vpn2;
        ent_asid[e]   <= wr_asid;
        ent_global[e] <= wr_global;
        ent_pfn[e]    <= wr_pfn;
        ent_v[e]      <= wr_v;
        ent_d[e]      <= wr_d;
      end
    end
  end

endmodule

// File: rtl/pgpair_tlb_match.sv
module pgpair_tlb_match #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int VPN2_W  = 19,
  parameter int ASID_W  = 8
) (
  input  logic [ENTRIES-1:0][VPN2_W-1:0] ent_vpn2,
  input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  input  logic [ENTRIES-1:0]             ent_global,
  input  logic [VPN2_W-1:0]              look_vpn2,
  input  logic [ASID_W-1:0]              look_asid,
  output logic                           any_match,
  output logic [IDX_W-1:0]               match_idx
);

  logic [ENTRIES-1:0] hit_vec;

  // One comparator per entry, all working at once.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic tag_eq, space_ok;
    assign tag_eq   = (ent_vpn2[e] == look_vpn2);
    assign space_ok = ent_global[e] || (ent_asid[e] == look_asid);
    assign hit_vec[e] = tag_eq && space_ok;
  end

  // Lowest-indexed hit wins: scan from the top so lower indices overwrite.
  always_comb begin
    match_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hit_vec[e]) match_idx = IDX_W'(e);
    end
  end

  assign any_match = |hit_vec;

endmodule

// File: rtl/pgpair_tlb_resolve.sv
module pgpair_tlb_resolve
  import pgpair_tlb_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int IDX_W     = 4,
  parameter int PFN_W     = 20,
  parameter int PAGE_BITS = 12,
  localparam int PA_W     = PFN_W + PAGE_BITS
) (
  input  logic [ENTRIES-1:0][1:0][PFN_W-1:0] ent_pfn,
  input  logic [ENTRIES-1:0][1:0]            ent_v,
  input  logic [ENTRIES-1:0][1:0]            ent_d,
  input  logic                               any_match,
  input  logic [IDX_W-1:0]                   match_idx,
  input  logic                               odd_half,
  input  logic                               is_store,
  input  logic [PAGE_BITS-1:0]               page_off,
  output xlat_status_e                       status,
  output logic [PA_W-1:0]                    pa,
  output logic                               rd_ok,
  output logic                               wr_ok
);

  logic [PFN_W-1:0] sel_pfn;
  logic             sel_v, sel_d;

  assign sel_pfn = ent_pfn[match_idx][odd_half];
  assign sel_v   = ent_v[match_idx][odd_half];
  assign sel_d   = ent_d[match_idx][odd_half];

  always_comb begin
    status = ST_HIT;
    if (!any_match)             status = ST_MISS;
    else if (!sel_v)            status = ST_INVALID;
    else if (is_store && !sel_d) status = ST_MODIFIED;
  end

  assign rd_ok = (status == ST_HIT);
  assign wr_ok = (status == ST_HIT) && sel_d;
  assign pa    = (status == ST_HIT) ? {sel_pfn, page_off} : '0;

endmodule

// File: rtl/pgpair_tlb.sv
module pgpair_tlb
  import pgpair_tlb_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 32,
  parameter int ASID_W    = 8,
  parameter int PAGE_BITS = 12,
  parameter int PFN_W     = 20,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int VPN2_W   = VA_W - PAGE_BITS - 1,
  localparam int PA_W     = PFN_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_store,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_rd_ok,
  output logic              rsp_wr_ok,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_even_pfn,
  input  logic              wr_even_v,
  input  logic              wr_even_d,
  input  logic [PFN_W-1:0]  wr_odd_pfn,
  input  logic              wr_odd_v,
  input  logic              wr_odd_d
);

  logic [ENTRIES-1:0][VPN2_W-1:0]     ent_vpn2;
  logic [ENTRIES-1:0][ASID_W-1:0]     ent_asid;
  logic [ENTRIES-1:0]                 ent_global;
  logic [ENTRIES-1:0][1:0][PFN_W-1:0] ent_pfn;
  logic [ENTRIES-1:0][1:0]            ent_v;
  logic [ENTRIES-1:0][1:0]            ent_d;

  logic [1:0][PFN_W-1:0] wr_pfn;
  logic [1:0]            wr_v, wr_d;

  assign wr_pfn[HALF_EVEN] = wr_even_pfn;
  assign wr_pfn[HALF_ODD]  = wr_odd_pfn;
  assign wr_v = {wr_odd_v, wr_even_v};
  assign wr_d = {wr_odd_d, wr_even_d};

  pgpair_tlb_store #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .VPN2_W(VPN2_W),
    .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_asid(wr_asid),
    .wr_global(wr_global), .wr_pfn(wr_pfn), .wr_v(wr_v), .wr_d(wr_d),
    .ent_vpn2(ent_vpn2), .ent_asid(ent_asid), .ent_global(ent_global),
    .ent_pfn(ent_pfn), .ent_v(ent_v), .ent_d(ent_d)
  );

  logic             any_match;
  logic [IDX_W-1:0] match_idx;

  pgpair_tlb_match #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .VPN2_W(VPN2_W), .ASID_W(ASID_W)
  ) u_match (
    .ent_vpn2(ent_vpn2), .ent_asid(ent_asid), .ent_global(ent_global),
    .look_vpn2(req_va[VA_W-1:PAGE_BITS+1]), .look_asid(req_asid),
    .any_match(any_match), .match_idx(match_idx)
  );

  xlat_status_e    nxt_status;
  logic [PA_W-1:0] nxt_pa;
  logic            nxt_rd, nxt_wr;

  pgpair_tlb_resolve #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .PFN_W(PFN_W), .PAGE_BITS(PAGE_BITS)
  ) u_resolve (
    .ent_pfn(ent_pfn), .ent_v(ent_v), .ent_d(ent_d),
    .any_match(any_match), .match_idx(match_idx),
    .odd_half(req_va[PAGE_BITS]), .is_store(req_store),
    .page_off(req_va[PAGE_BITS-1:0]),
    .status(nxt_status), .pa(nxt_pa), .rd_ok(nxt_rd), .wr_ok(nxt_wr)
  );

  // Output register stage: one cycle from strobe to response.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_MISS;
      rsp_pa     <= '0;
      rsp_rd_ok  <= 1'b0;
      rsp_wr_ok  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_status <= nxt_status;
        rsp_pa     <= nxt_pa;
        rsp_rd_ok  <= nxt_rd;
        rsp_wr_ok  <= nxt_wr;
      end
    end
  end

endmodule

// File: rtl/pgpair_tlb_checker.sv
module pgpair_tlb_checker #(
  parameter int PAGE_BITS = 12,
  parameter int PA_W      = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic [PAGE_BITS-1:0] req_off,
  input logic                 req_store,
  input logic                 rsp_valid,
  input logic [1:0]           rsp_status,
  input logic [PA_W-1:0]      rsp_pa,
  input logic                 rsp_rd_ok,
  input logic                 rsp_wr_ok
);

  assert_rsp_after_req_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_rsp_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_fault_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != 2'b00) |-> (!rsp_rd_ok && !rsp_wr_ok && rsp_pa == '0));

  assert_hit_readable_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'b00) |-> rsp_rd_ok);

  assert_offset_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'b00) |-> rsp_pa[PAGE_BITS-1:0] == $past(req_off));

  assert_load_never_modified_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(req_store)) |-> rsp_status != 2'b11);

endmodule

bind pgpair_tlb pgpair_tlb_checker #(.PAGE_BITS(PAGE_BITS), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid),
  .req_off(req_va[PAGE_BITS-1:0]), .req_store(req_store),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_pa(rsp_pa),
  .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok)
);

// File: tb/pgpair_tlb_test.sv
module pgpair_tlb_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [7:0]  req_asid = '0;
  logic        req_store = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_pa;
  logic        rsp_rd_ok, rsp_wr_ok;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [18:0] wr_vpn2 = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [19:0] wr_even_pfn = '0, wr_odd_pfn = '0;
  logic        wr_even_v = 1'b0, wr_even_d = 1'b0, wr_odd_v = 1'b0, wr_odd_d = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pgpair_tlb uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_asid(req_asid), .req_store(req_store), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_pa(rsp_pa), .rsp_rd_ok(rsp_rd_ok),
    .rsp_wr_ok(rsp_wr_ok), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2),
    .wr_asid(wr_asid), .wr_global(wr_global), .wr_even_pfn(wr_even_pfn),
    .wr_even_v(wr_even_v), .wr_even_d(wr_even_d), .wr_odd_pfn(wr_odd_pfn),
    .wr_odd_v(wr_odd_v), .wr_odd_d(wr_odd_d)
  );

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // Compare a whole response against values derived from the requirements.
  task automatic check_rsp(input string req, input logic [1:0] st,
                           input logic [31:0] pa, input logic rd, input logic wr);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_status !== st || rsp_pa !== pa ||
        rsp_rd_ok !== rd || rsp_wr_ok !== wr) begin
      errors++;
      $display("FAIL %s: actual v=%0b st=%b pa=%h rd=%0b wr=%0b expected v=1 st=%b pa=%h rd=%0b wr=%0b",
               req, rsp_valid, rsp_status, rsp_pa, rsp_rd_ok, rsp_wr_ok, st, pa, rd, wr);
    end
  endtask

  task automatic set_entry(input logic [3:0] idx, input logic [31:0] va,
                           input logic [7:0] asid, input logic g,
                           input logic [19:0] epfn, input logic ev, input logic ed,
                           input logic [19:0] opfn, input logic ov, input logic od);
    wr_idx = idx; wr_vpn2 = va[31:13]; wr_asid = asid; wr_global = g;
    wr_even_pfn = epfn; wr_even_v = ev; wr_even_d = ed;
    wr_odd_pfn = opfn; wr_odd_v = ov; wr_odd_d = od;
  endtask

  task automatic write_entry(input logic [3:0] idx, input logic [31:0] va,
                             input logic [7:0] asid, input logic g,
                             input logic [19:0] epfn, input logic ev, input logic ed,
                             input logic [19:0] opfn, input logic ov, input logic od);
    @(negedge clk);
    set_entry(idx, va, asid, g, epfn, ev, ed, opfn, ov, od);
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Strobe one lookup; on return the registered response is stable.
  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic st);
    @(negedge clk);
    req_va = va; req_asid = asid; req_store = st; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    check_bit("R1 rsp_valid low after reset", rsp_valid, 1'b0);
    lookup(32'h0000_0000, 8'h00, 1'b0);
    check_rsp("R1 zeroed entry gives invalid", 2'b10, 32'h0, 1'b0, 1'b0);
    lookup(32'h1234_5000, 8'h03, 1'b0);
    check_rsp("R1/R6 empty buffer misses", 2'b01, 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    check_bit("R2 no response without strobe", rsp_valid, 1'b0);
  endtask

  task automatic t_basic;
    write_entry(4'd2, 32'h1234_4000, 8'h05, 1'b0,
                20'hABCDE, 1'b1, 1'b1, 20'h11111, 1'b1, 1'b0);
    lookup(32'h1234_4ABC, 8'h05, 1'b0);
    check_rsp("R3/R4/R5 even load hit", 2'b00, 32'hABCD_EABC, 1'b1, 1'b1);
    lookup(32'h1234_4004, 8'h05, 1'b1);
    check_rsp("R9 even store to dirty page", 2'b00, 32'hABCD_E004, 1'b1, 1'b1);
    lookup(32'h1234_5123, 8'h05, 1'b0);
    check_rsp("R4/R9 odd load clean page", 2'b00, 32'h1111_1123, 1'b1, 1'b0);
    lookup(32'h1234_5123, 8'h05, 1'b1);
    check_rsp("R8 store to clean page", 2'b11, 32'h0, 1'b0, 1'b0);
    lookup(32'h1234_4ABC, 8'h06, 1'b0);
    check_rsp("R3 other address space misses", 2'b01, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_global;
    write_entry(4'd7, 32'h4000_0000, 8'h09, 1'b1,
                20'h22222, 1'b0, 1'b0, 20'h33333, 1'b1, 1'b1);
    lookup(32'h4000_1FFF, 8'h77, 1'b1);
    check_rsp("R3 global entry ignores space number", 2'b00, 32'h3333_3FFF, 1'b1, 1'b1);
    lookup(32'h4000_0010, 8'h77, 1'b0);
    check_rsp("R7 invalid half on load", 2'b10, 32'h0, 1'b0, 1'b0);
    lookup(32'h4000_0010, 8'h09, 1'b1);
    check_rsp("R7 invalid half on store", 2'b10, 32'h0, 1'b0, 1'b0);
    lookup(32'h4000_2000, 8'h77, 1'b0);
    check_rsp("R3 bit 13 differs so miss", 2'b01, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_priority;
    write_entry(4'd10, 32'h6000_0000, 8'h00, 1'b1,
                20'h55555, 1'b1, 1'b1, 20'h55555, 1'b1, 1'b1);
    write_entry(4'd4, 32'h6000_0000, 8'h00, 1'b1,
                20'h44444, 1'b1, 1'b1, 20'h44444, 1'b1, 1'b1);
    lookup(32'h6000_0042, 8'h31, 1'b0);
    check_rsp("R10 lowest index wins", 2'b00, 32'h4444_4042, 1'b1, 1'b1);
    write_entry(4'd4, 32'h7000_0000, 8'h00, 1'b1,
                20'h44444, 1'b1, 1'b1, 20'h44444, 1'b1, 1'b1);
    lookup(32'h6000_0042, 8'h31, 1'b0);
    check_rsp("R10/R11 replaced entry leaves next match", 2'b00, 32'h5555_5042, 1'b1, 1'b1);
  endtask

  task automatic t_overlap;
    @(negedge clk);
    set_entry(4'd12, 32'h0080_0000, 8'h21, 1'b0,
              20'h0ABCD, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
    wr_en = 1'b1;
    req_va = 32'h0080_0010; req_asid = 8'h21; req_store = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check_rsp("R11 same-cycle lookup sees old contents", 2'b01, 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R11 next lookup sees new entry", 2'b00, 32'h0ABC_D010, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_global();
    t_priority();
    t_overlap();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule